// File: doc/BRIEF.md
# T1 Per-Channel Transmit Transparency Processor

This block sits in the transmit path of a T1 framer. It takes one outgoing DS0 channel byte at a time and produces the byte that goes on the line. Every byte arrives with its channel index, its frame number within the 12-frame superframe and the A/B signaling bits for that channel. Each channel has one transparency ("clear") bit. A non-clear channel gets robbed-bit signaling in frames 6 and 12. It also gets zero-suppression stuffing: bit 7 is forced to 1 when the byte would otherwise be all zeros. A clear channel passes through untouched by both.

Two controls act across all channels. The first is a yellow-alarm request that applies in D4 mode only. It forces bit 2 low in every channel, clear channels included. The second is a pair of global stuffing bits. When both are set, stuffing is applied to every channel and the mask then decides only where signaling goes. The 24-bit mask is written as three bytes through a small write port. Bits are numbered 1 (MSB, first on the line) to 8 (LSB), so bit 2 is `data[6]`, bit 7 is `data[1]` and bit 8 is `data[0]`.

Top module: `t1_tx_clear_proc`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears `out_valid`, `out_byte` and all 24 mask bits. After reset every channel is non-clear.
- R2: A write with `cfg_wr`=1 loads `cfg_data` into one byte of the mask, chosen by `cfg_sel`. Select 0 holds channel indices 0..7, select 1 holds 8..15 and select 2 holds 16..23, with the lowest index in bit 0. Select 3 changes nothing. A written value applies to bytes presented in later cycles, not to a byte presented in the same cycle as the write.
- R3: For a non-clear channel, bit 8 (`data[0]`) is replaced by `sig_a` when `in_frame`=6 and by `sig_b` when `in_frame`=12. In every other frame it passes unchanged.
- R4: For a clear channel (mask bit 1), no signaling is inserted and no stuffing is applied.
- R5: When stuffing applies, the check is made on the byte after signaling insertion. If that byte is 0x00, bit 7 (`data[1]`) is set, which gives 0x02.
- R6: When `b7_all_a` and `b7_all_b` are both 1, stuffing applies to every channel, clear or not. The mask still blocks signaling in clear channels. Either bit set on its own has no effect.
- R7: When `mode_d4`=1 and `yellow_req`=1, bit 2 (`data[6]`) of every output byte is 0, clear channels included. This overwrite comes after the stuffing decision. With `mode_d4`=0 the yellow request has no effect.
- R8: `out_valid` at each rising edge takes the value of `in_valid`, and `out_byte` is the processed byte one clock after it is presented. When `in_valid` is low, `out_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Mask byte write strobe |
| cfg_sel | input | 2 | Mask byte select (0..2; 3 ignored) |
| cfg_data | input | 8 | Mask byte value |
| in_valid | input | 1 | Channel byte present |
| in_byte | input | 8 | Outgoing channel byte, bit 1 in `[7]` |
| in_chan | input | 5 | Channel index 0..23 |
| in_frame | input | 4 | Frame number 1..12 in the superframe |
| sig_a | input | 1 | Signaling bit A for this channel |
| sig_b | input | 1 | Signaling bit B for this channel |
| mode_d4 | input | 1 | 1 selects D4 framing mode |
| yellow_req | input | 1 | Yellow alarm being transmitted |
| b7_all_a | input | 1 | Global stuffing override, first bit |
| b7_all_b | input | 1 | Global stuffing override, second bit |
| out_valid | output | 1 | Processed byte valid |
| out_byte | output | 8 | Processed channel byte |

## Verification
Each processed byte is due at the first rising edge after the cycle in which it is presented. A mask write reaches the mask at that same edge, so it first affects the byte presented in the following cycle. The bench drives every input on the falling edge and samples the outputs at the next falling edge, half a cycle after the register has updated. Its reference model computes the expected byte from the mask as it stood before that cycle's write, and it applies the write to the model only after the edge.

// File: rtl/t1clr_pkg.sv
// Package t1clr_pkg
// Shared constants for the T1 transmit transparency processor. Bit
// positions follow the line convention: bit 1 is the MSB and is sent first.
package t1clr_pkg;
    localparam int BYTE_W    = 8;
    localparam int POS_BIT2  = 6;   // bit 2, cleared by the yellow alarm
    localparam int POS_BIT7  = 1;   // bit 7, the stuffing bit
    localparam int POS_BIT8  = 0;   // bit 8, the robbed signaling bit
    localparam int FRAME_W   = 4;
    localparam int SIG_FRM_A = 6;
    localparam int SIG_FRM_B = 12;
endpackage

// File: rtl/clr_mask_bank.sv
// Module clr_mask_bank
// Holds the per-channel clear mask as a bank of byte-wide registers. Each
// register is written when the select matches its index. A select beyond
// the last register writes nothing.
// Assumes: synchronous active-low reset, one write per cycle at most.
module clr_mask_bank #(
    parameter int NCH   = 24,
    parameter int REG_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] sel,
    input  logic [REG_W-1:0] wdata,
    output logic [NCH-1:0]   mask
);
    localparam int NREG = (NCH + REG_W - 1) / REG_W;

    logic [NREG*REG_W-1:0] bank_flat;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [REG_W-1:0] bank_q;

        // Load this mask byte on a matching write, clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q <= '0;
            else if (wr && sel == SEL_W'(r))
                bank_q <= wdata;
        end

        assign bank_flat[r*REG_W +: REG_W] = bank_q;

        assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && sel == SEL_W'(r)) |=> (bank_q == $past(wdata)));
    end

    assign mask = bank_flat[NCH-1:0];
endmodule

// File: rtl/chan_byte_path.sv
// Module chan_byte_path
// Combinational edit of one channel byte, in three steps: robbed-bit
// signaling insertion, zero-suppression stuffing, then the D4 yellow-alarm
// bit-2 overwrite.
// Assumes: frame numbers 1..12; clear and override are already resolved.
module chan_byte_path
    import t1clr_pkg::*;
(
    input  logic [BYTE_W-1:0]  data,
    input  logic               clear,
    input  logic [FRAME_W-1:0] frame,
    input  logic               sig_a,
    input  logic               sig_b,
    input  logic               d4_mode,
    input  logic               yellow,
    input  logic               ovr_all,
    output logic [BYTE_W-1:0]  result
);
    logic [BYTE_W-1:0] after_sig;
    logic [BYTE_W-1:0] after_stuff;

    // Step 1: put the A or B signaling bit in bit 8 of non-clear channels.
    always_comb begin
        after_sig = data;
        if (!clear) begin
            if (frame == FRAME_W'(SIG_FRM_A))
                after_sig[POS_BIT8] = sig_a;
            else if (frame == FRAME_W'(SIG_FRM_B))
                after_sig[POS_BIT8] = sig_b;
        end
    end

    // Step 2: set bit 7 of an all-zero byte wherever stuffing is allowed.
    always_comb begin
        after_stuff = after_sig;
        if ((!clear || ovr_all) && after_sig == '0)
            after_stuff[POS_BIT7] = 1'b1;
    end

    // Step 3: clear bit 2 in every channel while the D4 yellow alarm is sent.
    always_comb begin
        result = after_stuff;
        if (d4_mode && yellow)
            result[POS_BIT2] = 1'b0;
    end
endmodule

// File: rtl/t1_tx_clear_proc.sv
// Module t1_tx_clear_proc
// Top of the T1 transmit transparency processor. It looks up the channel's
// clear bit, edits the byte and registers the result with one clock of
// latency. The valid strobe follows the input valid.
// Assumes: in_chan is 0..NCH-1 (an index beyond that is treated as
// non-clear); synchronous active-low reset.
module t1_tx_clear_proc
    import t1clr_pkg::*;
#(
    parameter int NCH   = 24,
    parameter int CH_W  = $clog2(NCH),
    parameter int SEL_W = $clog2((NCH + BYTE_W - 1) / BYTE_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [BYTE_W-1:0]  cfg_data,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_byte,
    input  logic [CH_W-1:0]    in_chan,
    input  logic [FRAME_W-1:0] in_frame,
    input  logic               sig_a,
    input  logic               sig_b,
    input  logic               mode_d4,
    input  logic               yellow_req,
    input  logic               b7_all_a,
    input  logic               b7_all_b,
    output logic               out_valid,
    output logic [BYTE_W-1:0]  out_byte
);
    logic [NCH-1:0]    mask;
    logic              chan_clear;
    logic [BYTE_W-1:0] edited;

    clr_mask_bank #(.NCH(NCH), .REG_W(BYTE_W), .SEL_W(SEL_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_data),
        .mask  (mask)
    );

    // Pick this channel's clear bit; an index out of range counts as non-clear.
    always_comb begin
        chan_clear = 1'b0;
        if (in_chan < CH_W'(NCH))
            chan_clear = mask[in_chan];
    end

    chan_byte_path u_path (
        .data    (in_byte),
        .clear   (chan_clear),
        .frame   (in_frame),
        .sig_a   (sig_a),
        .sig_b   (sig_b),
        .d4_mode (mode_d4),
        .yellow  (yellow_req),
        .ovr_all (b7_all_a && b7_all_b),
        .result  (edited)
    );

    // Register the edited byte and the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_byte <= edited;
        end
    end

    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_byte)));
    assert_clear_bit8_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chan_clear) |=> (out_byte[POS_BIT8] == $past(in_byte[POS_BIT8])));
    assert_yellow_bit2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_d4 && yellow_req) |=> !out_byte[POS_BIT2]);
    assert_override_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && b7_all_a && b7_all_b && !(mode_d4 && yellow_req)) |=> (out_byte != '0));
endmodule

// File: tb/tb_t1_tx_clear_proc.sv
module tb_t1_tx_clear_proc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_data = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic [4:0] in_chan = '0;
    logic [3:0] in_frame = 4'd1;
    logic       sig_a = 1'b0, sig_b = 1'b0;
    logic       mode_d4 = 1'b0, yellow_req = 1'b0;
    logic       b7_all_a = 1'b0, b7_all_b = 1'b0;
    logic       out_valid;
    logic [7:0] out_byte;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    bit [23:0] m_mask = '0;
    bit        e_valid = 0;
    bit [7:0]  e_byte = 0;

    always #5 clk = ~clk;

    t1_tx_clear_proc dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .in_valid(in_valid), .in_byte(in_byte),
        .in_chan(in_chan), .in_frame(in_frame), .sig_a(sig_a), .sig_b(sig_b),
        .mode_d4(mode_d4), .yellow_req(yellow_req), .b7_all_a(b7_all_a),
        .b7_all_b(b7_all_b), .out_valid(out_valid), .out_byte(out_byte)
    );

    // Reference: follows the requirement text, bit 1 = MSB.
    function automatic bit [7:0] model(bit [7:0] b, int ch, int fr, bit a, bit bb,
                                       bit d4, bit yel, bit oa, bit ob, bit [23:0] mk);
        bit clr = (ch < 24) ? mk[ch] : 1'b0;
        bit [7:0] v = b;
        if (!clr && fr == 6)  v[0] = a;
        if (!clr && fr == 12) v[0] = bb;
        if ((!clr || (oa && ob)) && v == 8'h00) v = 8'h02;
        if (d4 && yel) v[6] = 1'b0;
        return v;
    endfunction

    task automatic check(string tag, bit [7:0] got_b, bit got_v, bit [7:0] exp_b, bit exp_v);
        checks++;
        if (got_v !== exp_v || got_b !== exp_b) begin
            errors++;
            $display("FAIL %s: got valid=%0b byte=%02h, expected valid=%0b byte=%02h",
                     tag, got_v, got_b, exp_v, exp_b);
        end
    endtask

    // One clock: inputs were set at the falling edge; sample one edge later.
    task automatic step(string tag);
        e_valid = in_valid;
        if (in_valid)
            e_byte = model(in_byte, int'(in_chan), int'(in_frame), sig_a, sig_b,
                           mode_d4, yellow_req, b7_all_a, b7_all_b, m_mask);
        @(posedge clk);
        if (cfg_wr && cfg_sel != 2'd3)
            m_mask[cfg_sel*8 +: 8] = cfg_data;
        @(negedge clk);
        check(tag, out_byte, out_valid, e_byte, e_valid);
        cfg_wr = 0;
        in_valid = 0;
    endtask

    task automatic send(int ch, int fr, bit [7:0] b, bit a, bit bb, string tag);
        in_valid = 1; in_chan = 5'(ch); in_frame = 4'(fr); in_byte = b;
        sig_a = a; sig_b = bb;
        step(tag);
    endtask

    task automatic wr(int sel, bit [7:0] d, string tag);
        cfg_wr = 1; cfg_sel = 2'(sel); cfg_data = d;
        step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", out_byte, out_valid, 8'h00, 1'b0);
        rst_n = 1;
        // R1: mask is zero after reset, so stuffing and signaling apply
        send(0, 1, 8'h00, 0, 0, "R1 default stuff ch0");
        send(23, 6, 8'h00, 1, 0, "R1 default sig ch23");
        // R3: signaling in frames 6 and 12 only
        send(4, 6, 8'hA5, 0, 1, "R3 frame6 A");
        send(4, 12, 8'h50, 0, 1, "R3 frame12 B");
        send(4, 3, 8'hA5, 0, 0, "R3 other frame");
        // R5: stuffing is decided after signaling
        send(9, 6, 8'h01, 0, 0, "R5 stuff after sig");
        send(9, 5, 8'h00, 1, 1, "R5 zero byte");
        // R2: same-cycle byte uses the old mask
        cfg_wr = 1; cfg_sel = 0; cfg_data = 8'h81;
        send(0, 1, 8'h00, 0, 0, "R2 write same cycle");
        send(0, 1, 8'h00, 0, 0, "R4 clear no stuff ch0");
        send(7, 6, 8'h00, 1, 0, "R4 clear no sig ch7");
        send(1, 1, 8'h00, 0, 0, "R2 ch1 still non-clear");
        wr(1, 8'h01, "R2 write sel1");
        send(8, 12, 8'h00, 0, 1, "R2 ch8 clear");
        wr(2, 8'h80, "R2 write sel2");
        send(23, 1, 8'h00, 0, 0, "R2 ch23 clear");
        send(16, 1, 8'h00, 0, 0, "R2 ch16 non-clear");
        wr(3, 8'hFF, "R2 write sel3 ignored");
        send(1, 1, 8'h00, 0, 0, "R2 sel3 left ch1");
        send(15, 1, 8'h00, 0, 0, "R2 sel3 left ch15");
        // R6: global stuffing override
        b7_all_a = 1;
        send(0, 1, 8'h00, 0, 0, "R6 one bit only");
        b7_all_b = 1;
        send(0, 1, 8'h00, 0, 0, "R6 override clear stuff");
        send(0, 6, 8'h00, 1, 0, "R6 override no sig");
        b7_all_a = 0; b7_all_b = 0;
        // R7: D4 yellow alarm clears bit 2 last
        mode_d4 = 1; yellow_req = 1;
        send(0, 1, 8'hFF, 0, 0, "R7 yellow clear ch");
        send(2, 1, 8'h40, 0, 0, "R7 yellow after stuff");
        mode_d4 = 0;
        send(2, 1, 8'hFF, 0, 0, "R7 non-D4 no effect");
        yellow_req = 0;
        // R8: idle cycle holds the byte and drops valid
        step("R8 idle hold");
        // Mixed random traffic against the model
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 5) == 0) begin
                cfg_wr = 1; cfg_sel = 2'($urandom_range(0, 3)); cfg_data = 8'($urandom);
            end
            mode_d4 = 1'($urandom); yellow_req = 1'($urandom_range(0, 3) == 0);
            b7_all_a = 1'($urandom); b7_all_b = 1'($urandom);
            in_valid = 1'($urandom_range(0, 4) != 0);
            in_chan = 5'($urandom_range(0, 23)); in_frame = 4'($urandom_range(1, 12));
            in_byte = ($urandom_range(0, 2) == 0) ? 8'($urandom_range(0, 1)) : 8'($urandom);
            sig_a = 1'($urandom); sig_b = 1'($urandom);
            step("R3 R4 R5 R6 R7 R8 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule